// File: doc/BRIEF.md
# PME Status Reset Sequencer

This block keeps the power-management event (PME) status and enable bits of a network controller. It also drives the output that asks external hardware to bring the system back to its working state. Three kinds of wake-up event can set the status bit: a magic packet seen, a wake pattern matched, and a change of link state. Each event has its own mask bit. Software clears the status by writing 1 to it, and it sets or clears the enable bit with a write strobe.

The block also produces the capability bit that says whether PME can be asserted from D3cold. That bit normally follows a synchronized auxiliary-power sense input. When the sense input is strapped out, a configuration bit held by software drives the capability bit directly.

The capability bit decides what a bus reset does to the PME bits. If the controller cannot signal PME from D3cold, a bus reset clears both status and enable. That clear waits until the configuration EEPROM load that follows the reset has finished. If the controller can signal PME from D3cold, the bits survive the bus reset. Only the power-on reset clears them.

Top module: `pme_status_seq`

## Requirements
- R1: While `por_n` is low, and on the first sample after it rises, `pme_status`, `pme_en`, `pme_wake` and `d3cold_cap` are all 0.
- R2: With `aux_bypass` = 0, `d3cold_cap` follows `aux_det` through SYNC_STAGES synchronizer flops and one output register. A change on `aux_det` therefore appears SYNC_STAGES+1 rising edges later.
- R3: With `aux_bypass` = 1, `d3cold_cap` takes the value of `sw_d3cold_cap` on the next rising edge, and `aux_det` has no effect.
- R4: The bits of `wake_evt` are: bit 0 magic packet, bit 1 pattern match, bit 2 link change. A 1 on any bit whose `wake_mask` bit is 1 sets `pme_status` on the next edge. An event whose mask bit is 0 leaves `pme_status` unchanged.
- R5: A 1 on `sts_w1c` clears `pme_status` on the next edge. An enabled event in the same cycle wins, and the status stays 1.
- R6: A 1 on `en_wr` loads `en_wdata` into `pme_en` on the next edge.
- R7: `pme_wake` is 1 exactly when `pme_status` and `pme_en` are both 1.
- R8: A `bus_rst` cycle arms a pending clear. If `d3cold_cap` is 0 when `eeprom_done` pulses, both `pme_status` and `pme_en` are 0 on the next edge. Before that pulse they keep their values. The clear wins over events and writes in the same cycle.
- R9: If `d3cold_cap` is 1 when the `eeprom_done` pulse consumes a pending clear, `pme_status` and `pme_en` are kept.
- R10: An `eeprom_done` pulse with no bus reset since the last consumed one has no effect on `pme_status` or `pme_en`.
- R11: An `eeprom_done` pulse in a cycle where `bus_rst` is 1 is ignored, and the clear stays pending for the next `eeprom_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| bus_rst | input | 1 | Bus reset indication, active high, synchronous |
| eeprom_done | input | 1 | One-cycle pulse when the configuration EEPROM load completes |
| aux_det | input | 1 | Auxiliary-power sense input, asynchronous |
| aux_bypass | input | 1 | 1 when the sense input is strapped out |
| sw_d3cold_cap | input | 1 | Software configuration value for the D3cold capability |
| wake_evt | input | N_EVT | Wake-up event pulses (0 magic packet, 1 pattern, 2 link change) |
| wake_mask | input | N_EVT | Per-event enable mask |
| en_wr | input | 1 | Write strobe for the PME enable bit |
| en_wdata | input | 1 | Value written to the PME enable bit |
| sts_w1c | input | 1 | Write-1-to-clear strobe for the PME status bit |
| d3cold_cap | output | 1 | Reported PME-from-D3cold capability |
| pme_status | output | 1 | PME status bit |
| pme_en | output | 1 | PME enable bit |
| pme_wake | output | 1 | Wake request to external hardware |

## Verification
The bench builds the block with its defaults: three event lines and two synchronizer stages. This brings each event type and its own mask bit within reach, along with the three-edge latency of the sense path. The bus-reset scenarios are driven once with the capability at 0 and once at 1. They also cover an EEPROM-done pulse with nothing pending, and one that arrives during a bus reset.

// File: rtl/pme_pkg.sv
package pme_pkg;

    typedef struct packed {
        logic status;
        logic en;
    } pme_bits_t;

    typedef struct packed {
        logic pend;
    } clr_state_t;

endpackage

// File: rtl/pme_cap_sel.sv
module pme_cap_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic aux_det,
    input  logic aux_bypass,
    input  logic sw_d3cold_cap,
    output logic cap_o
);
    localparam int SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    typedef struct packed {
        logic [SW-1:0] sync;
        logic          cap;
    } cap_state_t;

    cap_state_t st_d, st_q;

    generate
        if (SW == 1) begin : g_one
            always_comb begin
                st_d.sync = aux_det;
                st_d.cap  = aux_bypass ? sw_d3cold_cap : st_q.sync[0];
            end
        end else begin : g_chain
            always_comb begin
                st_d.sync = {st_q.sync[SW-2:0], aux_det};
                st_d.cap  = aux_bypass ? sw_d3cold_cap : st_q.sync[SW-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o = st_q.cap;

    p_bypass_r3: assert property (@(posedge clk) disable iff (!por_n)
        aux_bypass |=> (cap_o == $past(sw_d3cold_cap)));

endmodule

// File: rtl/pme_wake_merge.sv
module pme_wake_merge #(
    parameter int N_EVT = 3
) (
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] mask,
    output logic             hit_o
);
    logic [N_EVT-1:0] hit_vec;

    generate
        for (genvar i = 0; i < N_EVT; i++) begin : g_evt
            assign hit_vec[i] = evt[i] & mask[i];
        end
    endgenerate

    assign hit_o = |hit_vec;

endmodule

// File: rtl/pme_clr_seq.sv
module pme_clr_seq
    import pme_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic bus_rst,
    input  logic eeprom_done,
    input  logic cap,
    output logic pend_o,
    output logic clr_o
);
    clr_state_t st_d, st_q;
    logic       consume;

    always_comb begin
        st_d    = st_q;
        consume = 1'b0;
        if (bus_rst) begin
            st_d.pend = 1'b1;
        end else if (eeprom_done && st_q.pend) begin
            st_d.pend = 1'b0;
            consume   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign clr_o  = consume & ~cap;

    p_rst_arms_r11: assert property (@(posedge clk) disable iff (!por_n)
        bus_rst |=> pend_o);

endmodule

// File: rtl/pme_status_seq.sv
module pme_status_seq
    import pme_pkg::*;
#(
    parameter int N_EVT       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             bus_rst,
    input  logic             eeprom_done,
    input  logic             aux_det,
    input  logic             aux_bypass,
    input  logic             sw_d3cold_cap,
    input  logic [N_EVT-1:0] wake_evt,
    input  logic [N_EVT-1:0] wake_mask,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             sts_w1c,
    output logic             d3cold_cap,
    output logic             pme_status,
    output logic             pme_en,
    output logic             pme_wake
);
    logic      cap;
    logic      any_hit;
    logic      pend;
    logic      clr;
    pme_bits_t pm_d, pm_q;

    pme_cap_sel #(.SYNC_STAGES(SYNC_STAGES)) i_cap (
        .clk(clk), .por_n(por_n), .aux_det(aux_det), .aux_bypass(aux_bypass),
        .sw_d3cold_cap(sw_d3cold_cap), .cap_o(cap)
    );

    pme_wake_merge #(.N_EVT(N_EVT)) i_merge (
        .evt(wake_evt), .mask(wake_mask), .hit_o(any_hit)
    );

    pme_clr_seq i_clr (
        .clk(clk), .por_n(por_n), .bus_rst(bus_rst), .eeprom_done(eeprom_done),
        .cap(cap), .pend_o(pend), .clr_o(clr)
    );

    always_comb begin
        pm_d = pm_q;
        if (en_wr)   pm_d.en     = en_wdata;
        if (sts_w1c) pm_d.status = 1'b0;
        if (any_hit) pm_d.status = 1'b1;
        if (clr) begin
            pm_d.status = 1'b0;
            pm_d.en     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pm_q <= '0;
        else        pm_q <= pm_d;
    end

    assign d3cold_cap = cap;
    assign pme_status = pm_q.status;
    assign pme_en     = pm_q.en;
    assign pme_wake   = pm_q.status & pm_q.en;

    p_evt_set_r4: assert property (@(posedge clk) disable iff (!por_n)
        (|(wake_evt & wake_mask) && !clr) |=> pme_status);

    p_w1c_r5: assert property (@(posedge clk) disable iff (!por_n)
        (sts_w1c && !(|(wake_evt & wake_mask))) |=> !pme_status);

    p_en_wr_r6: assert property (@(posedge clk) disable iff (!por_n)
        (en_wr && !clr) |=> (pme_en == $past(en_wdata)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (!pme_status && !pme_en));

    p_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
        (eeprom_done && pend && d3cold_cap && !en_wr) |=> $stable(pme_en));

    p_idle_done_r10: assert property (@(posedge clk) disable iff (!por_n)
        (eeprom_done && !pend && !en_wr) |=> $stable(pme_en));

endmodule

// File: tb/test_pme_status_seq.sv
module test_pme_status_seq;
    localparam int CLK_PERIOD = 10;
    localparam int N_EVT = 3;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic bus_rst = 0, eeprom_done = 0, aux_det = 0, aux_bypass = 0, sw_d3cold_cap = 0;
    logic [N_EVT-1:0] wake_evt = '0, wake_mask = '0;
    logic en_wr = 0, en_wdata = 0, sts_w1c = 0;
    logic d3cold_cap, pme_status, pme_en, pme_wake;
    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pme_status_seq #(.N_EVT(N_EVT), .SYNC_STAGES(2)) i_pme_status_seq (
        .clk(clk), .por_n(por_n), .bus_rst(bus_rst), .eeprom_done(eeprom_done),
        .aux_det(aux_det), .aux_bypass(aux_bypass), .sw_d3cold_cap(sw_d3cold_cap),
        .wake_evt(wake_evt), .wake_mask(wake_mask), .en_wr(en_wr), .en_wdata(en_wdata),
        .sts_w1c(sts_w1c), .d3cold_cap(d3cold_cap), .pme_status(pme_status),
        .pme_en(pme_en), .pme_wake(pme_wake)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cap_sw(input logic v);
        aux_bypass = 1; sw_d3cold_cap = v;
        tick();
    endtask

    task automatic arm_bits();
        wake_mask = 3'b111; wake_evt = 3'b001; en_wr = 1; en_wdata = 1;
        tick();
        wake_evt = '0; en_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1 status in reset", pme_status, 1'b0);
        chk("R1 en in reset", pme_en, 1'b0);
        por_n = 1;
        tick();
        chk("R1 status after reset", pme_status, 1'b0);
        chk("R1 wake after reset", pme_wake, 1'b0);
        chk("R1 cap after reset", d3cold_cap, 1'b0);
    endtask

    task automatic t_cap_aux();
        aux_bypass = 0; aux_det = 1;
        tick(); tick();
        chk("R2 cap not yet after 2 edges", d3cold_cap, 1'b0);
        tick();
        chk("R2 cap after 3 edges", d3cold_cap, 1'b1);
        aux_det = 0;
        tick(); tick(); tick();
        chk("R2 cap falls", d3cold_cap, 1'b0);
    endtask

    task automatic t_cap_sw();
        aux_det = 1;
        set_cap_sw(1'b1);
        chk("R3 cap follows sw 1", d3cold_cap, 1'b1);
        set_cap_sw(1'b0);
        chk("R3 cap follows sw 0", d3cold_cap, 1'b0);
        tick(); tick(); tick();
        chk("R3 aux ignored in bypass", d3cold_cap, 1'b0);
        aux_det = 0;
    endtask

    task automatic t_events();
        for (int i = 0; i < N_EVT; i++) begin
            wake_mask = 3'b111 ^ (3'b001 << i);
            wake_evt = 3'b001 << i;
            tick();
            chk("R4 masked event ignored", pme_status, 1'b0);
            wake_mask = 3'b001 << i;
            tick();
            wake_evt = '0;
            chk("R4 enabled event sets", pme_status, 1'b1);
            sts_w1c = 1;
            tick();
            sts_w1c = 0;
            chk("R5 w1c clears", pme_status, 1'b0);
        end
        wake_mask = 3'b100; wake_evt = 3'b100; sts_w1c = 1;
        tick();
        wake_evt = '0; sts_w1c = 0;
        chk("R5 event beats w1c", pme_status, 1'b1);
    endtask

    task automatic t_enable();
        chk("R7 wake off when en 0", pme_wake, 1'b0);
        en_wr = 1; en_wdata = 1;
        tick();
        en_wr = 0;
        chk("R6 en written 1", pme_en, 1'b1);
        chk("R7 wake on", pme_wake, 1'b1);
        en_wr = 1; en_wdata = 0;
        tick();
        en_wr = 0;
        chk("R6 en written 0", pme_en, 1'b0);
        chk("R7 wake off", pme_wake, 1'b0);
        sts_w1c = 1;
        tick();
        sts_w1c = 0;
    endtask

    task automatic t_clear_cap0();
        set_cap_sw(1'b0);
        arm_bits();
        bus_rst = 1;
        tick();
        bus_rst = 0;
        tick(); tick();
        chk("R8 status kept during load", pme_status, 1'b1);
        chk("R8 en kept during load", pme_en, 1'b1);
        eeprom_done = 1; wake_evt = 3'b010; en_wr = 1; en_wdata = 1;
        tick();
        eeprom_done = 0; wake_evt = '0; en_wr = 0;
        chk("R8 status cleared after done", pme_status, 1'b0);
        chk("R8 en cleared after done", pme_en, 1'b0);
    endtask

    task automatic t_keep_cap1();
        set_cap_sw(1'b1);
        arm_bits();
        bus_rst = 1;
        tick();
        bus_rst = 0;
        eeprom_done = 1;
        tick();
        eeprom_done = 0;
        chk("R9 status kept cap 1", pme_status, 1'b1);
        chk("R9 en kept cap 1", pme_en, 1'b1);
    endtask

    task automatic t_idle_done();
        set_cap_sw(1'b0);
        eeprom_done = 1;
        tick();
        eeprom_done = 0;
        chk("R10 status kept idle done", pme_status, 1'b1);
        chk("R10 en kept idle done", pme_en, 1'b1);
    endtask

    task automatic t_done_in_rst();
        bus_rst = 1; eeprom_done = 1;
        tick();
        bus_rst = 0; eeprom_done = 0;
        chk("R11 done during reset ignored", pme_en, 1'b1);
        tick();
        eeprom_done = 1;
        tick();
        eeprom_done = 0;
        chk("R11 later done clears", pme_en, 1'b0);
        chk("R11 later done clears status", pme_status, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        tick();
        t_reset();
        t_cap_aux();
        t_cap_sw();
        t_events();
        t_enable();
        t_clear_cap0();
        t_keep_cap1();
        t_idle_done();
        t_done_in_rst();
        done_flag = 1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done_flag; c++) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule